// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block sits on the device side of an asynchronous NOR-style memory bus. The chip-select, write-strobe, read-strobe and abort lines are brought into a system clock domain through synchronising registers. The end of each write strobe is treated as one bus write. A sequence decoder must see a fixed pair of unlock writes before it accepts a command. It recognises three commands: byte program, sector erase and full-array erase.

Accepted operations run on clock-count timers and act on a small register array that is split into equal sectors. While an operation runs, `ready` is held low. Reads that hit the location or sector under operation return a status byte instead of data:
- bit 7 holds the complement of the final bit 7.
- bit 6 inverts on every read made while the block is busy.

Reads and programs to sectors that are not being erased keep working during a sector erase.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: The program sequence is four bus writes: AAh to address 5555h, 55h to 2AAAh, A0h to 5555h, then the data to the target. It stores a value into the byte at the low address bits of the target, PROG_CYC clocks after acceptance.
- R2: Programming can only clear bits. The stored byte becomes the old byte AND the written data.
- R3: The sector erase sequence is AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 30h to any address in the sector. The sector index is the top SECT_W bits of the array address. The erase sets every byte of that sector to FFh and leaves the other sectors unchanged.
- R4: The same five-write prefix followed by 10h@5555h sets every byte of the array to FFh.
- R5: A write that does not match the expected step returns the decoder to read mode. Later writes of that broken sequence leave the array unchanged and start no operation.
- R6: `ready` is 0 from the clock after a command is accepted until its operation completes, and 1 otherwise.
- R7: During an operation, a read of the byte being programmed returns {~data[7], toggle, 000000b}. A read of a byte in a sector being erased returns {0, toggle, 000000b}. After completion the same read returns the stored byte.
- R8: The toggle bit (bit 6 of the status byte) inverts on every read strobe that starts while `ready` is 0. Two consecutive status reads therefore differ in bit 6.
- R9: After a sector erase is accepted, each further write of 30h within WIN_CYC clocks adds the addressed sector to the same erase.
- R10: During a sector erase, reads and programs to sectors outside the erase proceed normally. A program aimed at an erasing sector is discarded.
- R11: Holding `reset_n` low aborts any operation without touching the array, raises `ready`, clears the toggle bit and returns the decoder to read mode.
- R12: After `rst_n` every array byte reads FFh and `ready` is 1. `dout` is 0 whenever chip select or output enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | System reset, active low; fills the array with FFh |
| reset_n | input | 1 | Asynchronous bus abort line, active low |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read strobe, active low |
| addr | input | ADDR_W | Bus address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or status byte |
| ready | output | 1 | High when no operation is running |

## Verification
A write is seen by the decoder on the third clock edge after its strobe rises. The resulting operation starts on the fourth edge, so `ready` is low when the bench's write task returns, four falling edges after the strobe release. The toggle flip from a read strobe lands on the third edge after the strobe falls. The bench therefore samples `dout` on the fourth falling edge of each read and keeps its own toggle model, which flips whenever `ready` was low at the start of the read. Completion is awaited by polling `ready` on falling edges before the final data reads, and no result is sampled on a rising edge.

// File: rtl/nor_cmd_pkg.sv
`timescale 1ns/1ps
package nor_cmd_pkg;
  localparam logic [14:0] KEY_A1   = 15'h5555;
  localparam logic [14:0] KEY_A2   = 15'h2AAA;
  localparam logic [7:0]  KEY_D1   = 8'hAA;
  localparam logic [7:0]  KEY_D2   = 8'h55;
  localparam logic [7:0]  OP_PROG  = 8'hA0;
  localparam logic [7:0]  OP_ERASE = 8'h80;
  localparam logic [7:0]  OP_CHIP  = 8'h10;
  localparam logic [7:0]  OP_SECT  = 8'h30;

  typedef enum logic [2:0] {
    SQ_READ, SQ_K1, SQ_K2, SQ_DATA, SQ_E1, SQ_E2, SQ_E3
  } seq_t;

  typedef enum logic [1:0] {ER_IDLE, ER_GATHER, ER_RUN} er_t;

  // bits can only be cleared by a program
  function automatic logic [7:0] prog_merge(input logic [7:0] old_b, input logic [7:0] new_b);
    return old_b & new_b;
  endfunction

  function automatic logic [7:0] poll_byte(input logic inv7, input logic tog);
    return {inv7, tog, 6'b0};
  endfunction

  function automatic logic key_hit(input logic [14:0] a, input logic [14:0] ka,
                                   input logic [7:0] d, input logic [7:0] kd);
    return (a == ka) && (d == kd);
  endfunction
endpackage

// File: rtl/nor_bus_sync.sv
`timescale 1ns/1ps
module nor_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic we_n,
  input  logic oe_n,
  input  logic reset_n,
  output logic wr_evt,
  output logic rd_evt,
  output logic pin_rst
);
  // lane 0: write active, lane 1: read active, lane 2: abort active
  logic [2:0] raw;
  logic [2:0] pipe_q [STAGES+1];
  logic [2:0] cur, prev;

  assign raw = {~reset_n, ~cs_n & ~oe_n, ~cs_n & ~we_n};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i <= STAGES; i++) pipe_q[i] <= 3'b000;
    end else begin
      pipe_q[0] <= raw;
      for (int i = 1; i <= STAGES; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign cur     = pipe_q[STAGES-1];
  assign prev    = pipe_q[STAGES];
  assign wr_evt  = prev[0] & ~cur[0];
  assign rd_evt  = cur[1] & ~prev[1];
  assign pin_rst = cur[2];

  // R5
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> !wr_evt);
endmodule

// File: rtl/nor_seq_decoder.sv
`timescale 1ns/1ps
module nor_seq_decoder
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int ARR_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_rst,
  input  logic              wr_evt,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic              prog_req,
  output logic              serase_req,
  output logic              cerase_req,
  output logic              add_req,
  output logic [ARR_W-1:0]  req_addr,
  output logic [7:0]        req_data
);
  seq_t st_q, st_d;
  logic [14:0] ka;
  logic hit1, hit2;
  logic p_d, s_d, c_d, a_d;

  assign ka   = addr[14:0];
  assign hit1 = key_hit(ka, KEY_A1, din, KEY_D1);
  assign hit2 = key_hit(ka, KEY_A2, din, KEY_D2);

  always_comb begin
    st_d = SQ_READ;
    p_d = 1'b0; s_d = 1'b0; c_d = 1'b0; a_d = 1'b0;
    case (st_q)
      SQ_READ: begin
        if (hit1) st_d = SQ_K1;
        else if (din == OP_SECT) a_d = 1'b1;
      end
      SQ_K1: if (hit2) st_d = SQ_K2;
      SQ_K2: begin
        if (key_hit(ka, KEY_A1, din, OP_PROG)) st_d = SQ_DATA;
        else if (key_hit(ka, KEY_A1, din, OP_ERASE)) st_d = SQ_E1;
      end
      SQ_DATA: p_d = 1'b1;
      SQ_E1: if (hit1) st_d = SQ_E2;
      SQ_E2: if (hit2) st_d = SQ_E3;
      SQ_E3: begin
        if (key_hit(ka, KEY_A1, din, OP_CHIP)) c_d = 1'b1;
        else if (din == OP_SECT) s_d = 1'b1;
      end
      default: st_d = SQ_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= SQ_READ;
      {prog_req, serase_req, cerase_req, add_req} <= 4'b0;
      req_addr <= '0;
      req_data <= 8'h00;
    end else begin
      {prog_req, serase_req, cerase_req, add_req} <= 4'b0;
      if (pin_rst) begin
        st_q <= SQ_READ;
      end else if (wr_evt) begin
        st_q       <= st_d;
        prog_req   <= p_d;
        serase_req <= s_d;
        cerase_req <= c_d;
        add_req    <= a_d;
        req_addr   <= addr[ARR_W-1:0];
        req_data   <= din;
      end
    end
  end

  // R5
  req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_req, serase_req, cerase_req, add_req}));
  // R11
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_rst |=> st_q == SQ_READ);
endmodule

// File: rtl/nor_op_engine.sv
`timescale 1ns/1ps
module nor_op_engine
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int NUM_SECT   = 4,
  parameter int SECT_BYTES = 16,
  parameter int PROG_CYC   = 48,
  parameter int WIN_CYC    = 32,
  parameter int SERASE_CYC = 96,
  parameter int CERASE_CYC = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_rst,
  input  logic              rd_evt,
  input  logic              rd_on,
  input  logic [ADDR_W-1:0] addr,
  input  logic              prog_req,
  input  logic              serase_req,
  input  logic              cerase_req,
  input  logic              add_req,
  input  logic [$clog2(NUM_SECT*SECT_BYTES)-1:0] req_addr,
  input  logic [7:0]        req_data,
  output logic [7:0]        dout,
  output logic              ready
);
  localparam int ARR_BYTES = NUM_SECT * SECT_BYTES;
  localparam int ARR_W     = $clog2(ARR_BYTES);
  localparam int SECT_W    = $clog2(NUM_SECT);
  localparam int CNT_W     = $clog2(PROG_CYC + WIN_CYC + SERASE_CYC + CERASE_CYC + 1);

  function automatic logic [SECT_W-1:0] sect_of(input logic [ARR_W-1:0] a);
    return a[ARR_W-1 -: SECT_W];
  endfunction

  logic [7:0]          arr_q [ARR_BYTES];
  logic                p_busy;
  logic [ARR_W-1:0]    p_addr;
  logic [7:0]          p_data;
  logic [CNT_W-1:0]    p_cnt, e_cnt;
  er_t                 e_st;
  logic [NUM_SECT-1:0] mask_q, req_hot;
  logic                tog;
  logic                e_busy, busy_any;
  logic                prog_go, se_go, ce_go, add_go;
  logic                p_fin, e_fin;
  logic [ARR_BYTES-1:0] wipe;
  logic [ARR_W-1:0]    rd_idx;
  logic [7:0]          p_cur;

  assign e_busy   = (e_st != ER_IDLE);
  assign busy_any = p_busy | e_busy;
  assign req_hot  = NUM_SECT'(1) << sect_of(req_addr);
  assign prog_go  = prog_req && !p_busy && !(e_busy && mask_q[sect_of(req_addr)]);
  assign se_go    = serase_req && !e_busy && !p_busy;
  assign ce_go    = cerase_req && !e_busy && !p_busy;
  assign add_go   = add_req && (e_st == ER_GATHER) &&
                    !(p_busy && sect_of(p_addr) == sect_of(req_addr));
  assign p_fin    = p_busy && (p_cnt == '0);
  assign e_fin    = (e_st == ER_RUN) && (e_cnt == '0);
  assign p_cur    = arr_q[p_addr];

  generate
    for (genvar g = 0; g < ARR_BYTES; g++) begin : g_wipe
      assign wipe[g] = e_fin && mask_q[g / SECT_BYTES];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || pin_rst) begin
      p_busy <= 1'b0;
      p_addr <= '0;
      p_data <= 8'hFF;
      p_cnt  <= '0;
      e_st   <= ER_IDLE;
      e_cnt  <= '0;
      mask_q <= '0;
      tog    <= 1'b0;
    end else begin
      if (p_fin) p_busy <= 1'b0;
      else if (p_busy) p_cnt <= p_cnt - 1'b1;
      if (prog_go) begin
        p_busy <= 1'b1;
        p_addr <= req_addr;
        p_data <= req_data;
        p_cnt  <= CNT_W'(PROG_CYC - 1);
      end
      case (e_st)
        ER_IDLE: begin
          if (se_go) begin
            e_st <= ER_GATHER; mask_q <= req_hot; e_cnt <= CNT_W'(WIN_CYC - 1);
          end else if (ce_go) begin
            e_st <= ER_RUN; mask_q <= '1; e_cnt <= CNT_W'(CERASE_CYC - 1);
          end
        end
        ER_GATHER: begin
          if (add_go) mask_q <= mask_q | req_hot;
          if (e_cnt == '0) begin
            e_st <= ER_RUN; e_cnt <= CNT_W'(SERASE_CYC - 1);
          end else e_cnt <= e_cnt - 1'b1;
        end
        ER_RUN: begin
          if (e_cnt == '0) begin
            e_st <= ER_IDLE; mask_q <= '0;
          end else e_cnt <= e_cnt - 1'b1;
        end
        default: e_st <= ER_IDLE;
      endcase
      if (rd_evt && busy_any) tog <= ~tog;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ARR_BYTES; i++) arr_q[i] <= 8'hFF;
    end else if (!pin_rst) begin
      for (int i = 0; i < ARR_BYTES; i++) if (wipe[i]) arr_q[i] <= 8'hFF;
      if (p_fin) arr_q[p_addr] <= prog_merge(arr_q[p_addr], p_data);
    end
  end

  assign rd_idx = addr[ARR_W-1:0];

  always_comb begin
    if (!rd_on) dout = 8'h00;
    else if (p_busy && rd_idx == p_addr) dout = poll_byte(~p_data[7], tog);
    else if (e_busy && mask_q[sect_of(rd_idx)]) dout = poll_byte(1'b0, tog);
    else dout = arr_q[rd_idx];
  end

  assign ready = ~busy_any;

  // R2
  prog_merge_chk: assert property (@(posedge clk) disable iff (!rst_n || pin_rst)
    p_fin |=> p_cur == ($past(p_cur) & $past(p_data)));
  // R10
  no_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p_busy && e_busy) |-> !mask_q[sect_of(p_addr)]);
  // R3
  erase_ff_chk: assert property (@(posedge clk) disable iff (!rst_n || pin_rst)
    (e_fin && mask_q[0]) |=> arr_q[0] == 8'hFF);
  // R6
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(p_fin || e_fin || pin_rst));
endmodule

// File: rtl/nor_cmd_ctrl.sv
`timescale 1ns/1ps
module nor_cmd_ctrl #(
  parameter int ADDR_W      = 15,
  parameter int NUM_SECT    = 4,
  parameter int SECT_BYTES  = 16,
  parameter int PROG_CYC    = 48,
  parameter int WIN_CYC     = 32,
  parameter int SERASE_CYC  = 96,
  parameter int CERASE_CYC  = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reset_n,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              ready
);
  localparam int ARR_W = $clog2(NUM_SECT * SECT_BYTES);

  logic wr_evt, rd_evt, pin_rst, rd_on;
  logic prog_req, serase_req, cerase_req, add_req;
  logic [ARR_W-1:0] req_addr;
  logic [7:0] req_data;

  assign rd_on = ~cs_n & ~oe_n;

  nor_bus_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .reset_n(reset_n), .wr_evt(wr_evt), .rd_evt(rd_evt), .pin_rst(pin_rst));

  nor_seq_decoder #(.ADDR_W(ADDR_W), .ARR_W(ARR_W)) dec_i (
    .clk(clk), .rst_n(rst_n), .pin_rst(pin_rst), .wr_evt(wr_evt),
    .addr(addr), .din(din), .prog_req(prog_req), .serase_req(serase_req),
    .cerase_req(cerase_req), .add_req(add_req), .req_addr(req_addr),
    .req_data(req_data));

  nor_op_engine #(
    .ADDR_W(ADDR_W), .NUM_SECT(NUM_SECT), .SECT_BYTES(SECT_BYTES),
    .PROG_CYC(PROG_CYC), .WIN_CYC(WIN_CYC), .SERASE_CYC(SERASE_CYC),
    .CERASE_CYC(CERASE_CYC)
  ) eng_i (
    .clk(clk), .rst_n(rst_n), .pin_rst(pin_rst), .rd_evt(rd_evt),
    .rd_on(rd_on), .addr(addr), .prog_req(prog_req), .serase_req(serase_req),
    .cerase_req(cerase_req), .add_req(add_req), .req_addr(req_addr),
    .req_data(req_data), .dout(dout), .ready(ready));
endmodule

// File: tb/nor_cmd_ctrl_tb_top.sv
`timescale 1ns/1ps
module nor_cmd_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reset_n = 1'b1;
  logic cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [14:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        ready;

  always #4 clk = ~clk;

  nor_cmd_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reset_n(reset_n), .cs_n(cs_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .din(din), .dout(dout), .ready(ready));

  typedef struct {
    bit         sel;   // 0: dout, 1: ready
    logic [7:0] exp;
    string      req;
  } item_t;

  item_t sb_q[$];
  item_t it;
  logic [7:0] act;
  int checks = 0;
  int fails = 0;
  logic smp_tick = 1'b0;
  logic tog_m = 1'b0;
  bit done = 0;

  // monitor: pops one expected item per sample tick
  initial forever begin
    @(smp_tick);
    if (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      act = it.sel ? {7'b0, ready} : dout;
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s actual=%h expected=%h", it.req, act, it.exp);
      end
    end
  end

  task automatic push_chk(input bit sel, input logic [7:0] exp, input string req);
    item_t n;
    n.sel = sel; n.exp = exp; n.req = req;
    sb_q.push_back(n);
    smp_tick = ~smp_tick;
    #1;
  endtask

  task automatic chk_ready(input logic exp, input string req);
    @(negedge clk);
    push_chk(1'b1, {7'b0, exp}, req);
  endtask

  task automatic bus_wr(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; din = d; cs_n = 1'b0; we_n = 1'b0;
    repeat (3) @(negedge clk);
    we_n = 1'b1; cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // status=1: expect {b7, toggle, 000000}; otherwise expect data
  task automatic bus_rd(input logic [14:0] a, input logic [7:0] data,
                        input bit status, input logic b7, input string req);
    logic was_busy;
    @(negedge clk);
    addr = a; cs_n = 1'b0; oe_n = 1'b0;
    was_busy = !ready;
    repeat (4) @(negedge clk);
    if (was_busy) tog_m = ~tog_m;
    push_chk(1'b0, status ? {b7, tog_m, 6'b0} : data, req);
    cs_n = 1'b1; oe_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic unlock();
    bus_wr(15'h5555, 8'hAA);
    bus_wr(15'h2AAA, 8'h55);
  endtask

  task automatic do_prog(input logic [14:0] a, input logic [7:0] d);
    unlock();
    bus_wr(15'h5555, 8'hA0);
    bus_wr(a, d);
  endtask

  task automatic erase_prefix();
    unlock();
    bus_wr(15'h5555, 8'h80);
    unlock();
  endtask

  task automatic wait_ready(input string req);
    int n = 0;
    while (ready !== 1'b1 && n < 2000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 2000) begin
      checks++; fails++;
      $display("FAIL %s actual=busy expected=ready", req);
    end
  endtask

  task automatic pin_abort();
    @(negedge clk);
    reset_n = 1'b0;
    repeat (4) @(negedge clk);
    reset_n = 1'b1;
    repeat (4) @(negedge clk);
    tog_m = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R12 reset state and idle output
    chk_ready(1'b1, "R12 ready after reset");
    @(negedge clk); push_chk(1'b0, 8'h00, "R12 dout idle");
    bus_rd(15'h0005, 8'hFF, 0, 1'b0, "R12 erased after reset");

    // R1 program, R6 busy, R7 polling, R8 toggle
    do_prog(15'h0005, 8'hA5);
    chk_ready(1'b0, "R6 busy during program");
    bus_rd(15'h0005, 8'h00, 1, 1'b0, "R7 program poll");
    bus_rd(15'h0005, 8'h00, 1, 1'b0, "R8 toggle second read");
    wait_ready("R6 program completes");
    chk_ready(1'b1, "R6 ready after program");
    bus_rd(15'h0005, 8'hA5, 0, 1'b0, "R1 programmed value");

    // R2 AND merge
    do_prog(15'h0005, 8'h5A);
    wait_ready("R2 program completes");
    bus_rd(15'h0005, 8'h00, 0, 1'b0, "R2 old AND new");

    // R5 broken sequence
    bus_wr(15'h5555, 8'hAA);
    bus_wr(15'h2AAB, 8'h55);
    bus_wr(15'h5555, 8'hA0);
    bus_wr(15'h0006, 8'h00);
    chk_ready(1'b1, "R5 no operation started");
    bus_rd(15'h0006, 8'hFF, 0, 1'b0, "R5 array untouched");

    // R3 sector erase, R10 access to other sector
    do_prog(15'h0012, 8'h0F);
    wait_ready("R10 setup program");
    erase_prefix();
    bus_wr(15'h0005, 8'h30);
    chk_ready(1'b0, "R6 busy during sector erase");
    bus_rd(15'h0005, 8'h00, 1, 1'b0, "R7 erase poll");
    bus_rd(15'h0012, 8'h0F, 0, 1'b0, "R10 read outside erase");
    do_prog(15'h0013, 8'h3C);
    wait_ready("R3 sector erase completes");
    bus_rd(15'h0005, 8'hFF, 0, 1'b0, "R3 sector erased");
    bus_rd(15'h0013, 8'h3C, 0, 1'b0, "R10 program outside erase");
    bus_rd(15'h0012, 8'h0F, 0, 1'b0, "R3 other sector kept");

    // R9 multi-sector erase, R10 discarded program
    do_prog(15'h0021, 8'h11);
    wait_ready("R9 setup 1");
    do_prog(15'h0031, 8'h22);
    wait_ready("R9 setup 2");
    erase_prefix();
    bus_wr(15'h0021, 8'h30);
    bus_wr(15'h0031, 8'h30);
    do_prog(15'h0022, 8'h00);
    wait_ready("R9 erase completes");
    bus_rd(15'h0021, 8'hFF, 0, 1'b0, "R9 first sector erased");
    bus_rd(15'h0031, 8'hFF, 0, 1'b0, "R9 added sector erased");
    bus_rd(15'h0022, 8'hFF, 0, 1'b0, "R10 program to erasing sector dropped");
    bus_rd(15'h0012, 8'h0F, 0, 1'b0, "R9 unselected sector kept");

    // R4 chip erase
    erase_prefix();
    bus_wr(15'h5555, 8'h10);
    bus_rd(15'h003F, 8'h00, 1, 1'b0, "R7 chip erase poll");
    wait_ready("R4 chip erase completes");
    bus_rd(15'h0012, 8'hFF, 0, 1'b0, "R4 byte 12h erased");
    bus_rd(15'h0013, 8'hFF, 0, 1'b0, "R4 byte 13h erased");

    // R11 abort during program
    do_prog(15'h0008, 8'h00);
    chk_ready(1'b0, "R11 busy before abort");
    pin_abort();
    chk_ready(1'b1, "R11 ready after abort");
    bus_rd(15'h0008, 8'hFF, 0, 1'b0, "R11 aborted program left no trace");
    // R11 abort mid-sequence returns to read mode
    unlock();
    bus_wr(15'h5555, 8'hA0);
    pin_abort();
    bus_wr(15'h0009, 8'h00);
    chk_ready(1'b1, "R11 no operation after abort");
    bus_rd(15'h0009, 8'hFF, 0, 1'b0, "R11 data write ignored");

    repeat (4) @(negedge clk);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule